// File: doc/BRIEF.md
# Write-Back Direct-Mapped Cache Controller

This block is a single-way data cache placed between a processor request port and a main-memory port whose latency is not known in advance. The processor raises a request with a read/write flag, a 32-bit byte address and write data, then holds it until the cache answers with a one-cycle ready pulse. A read returns the addressed 32-bit word. A write merges the new word into the cached block.

The cache has 1024 sets, and each set holds a 128-bit block of four words. Each set has a tag, a valid flag and a dirty flag. On a miss, the controller first copies a modified victim block back to memory. It then fetches the requested block and checks the tags again. After the fill the access completes as a hit. Every memory transfer is a whole block, and the memory ends each transfer with a ready pulse.

The controller is a Moore machine with four states: waiting, tag compare, victim write-back and block fill. The address is split as follows: tag in bits 31..14, set index in bits 13..4, word select in bits 3..2, and the byte offset in bits 1..0, which the cache ignores.

Top module: `wb_cache_ctrl`

## Requirements
- R1: After reset no set is valid, so the first access to any address issues a memory block read. While idle after reset, `cpu_ready` and `mem_req` are low.
- R2: A hit raises `cpu_ready` on the first clock edge after the edge that accepts the request. No memory request is issued for that access.
- R3: A read returns the word selected by address bits 3..2, holding the most recently written value for that word address.
- R4: A write changes only the selected word. The other three words of the block keep their values.
- R5: A miss whose victim is clean or invalid issues exactly one memory read, and no memory write, at block address {tag, index, 4'b0000}.
- R6: A miss whose victim is valid and dirty first writes the whole 128-bit victim block to {stored tag, index, 4'b0000}, holding the latest data, and then reads the new block.
- R7: While `mem_ready` is low, `mem_req`, `mem_we` and `mem_addr` stay unchanged, however long memory takes.
- R8: After a fill, the controller returns to tag compare and completes the access as a hit. A filled block starts clean and becomes dirty only when written.
- R9: Within a 128-bit block, word k sits at bits [32k+31:32k], on both the memory read and the memory write path.
- R10: `cpu_ready` is high for exactly one cycle per request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_valid | input | 1 | Processor request present, held until cpu_ready |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 32 | Byte address |
| cpu_wdata | input | 32 | Write word |
| cpu_ready | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | 32 | Read word, valid while cpu_ready is high |
| mem_req | output | 1 | Memory transfer requested |
| mem_we | output | 1 | 1 = block write-back, 0 = block fill |
| mem_addr | output | 32 | Block-aligned byte address |
| mem_wdata | output | 128 | Victim block |
| mem_rdata | input | 128 | Fill block |
| mem_ready | input | 1 | Memory completes the current transfer |

## Verification
A lost or wrong dirty flag does not show up right away. It shows up only when that set is next evicted: either a write-back is missing, or an unneeded write carries stale words. For this reason the bench compares every victim block against its own record of the latest writes. A wrong tag or valid flag shows up at once: the access after a fill either takes a memory trip it should not, or returns data from the wrong block. Hit latency and transfer counts are checked on every access, using a reference tag model. Random latency in the memory model exercises the address-hold rule.

// File: rtl/wb_cache_ctrl.sv
module wb_cache_ctrl #(
  parameter int ADDR_W  = 32,
  parameter int INDEX_W = 10,
  parameter int WORDS   = 4,
  parameter int WORD_W  = 32
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cpu_valid,
  input  logic                    cpu_we,
  input  logic [ADDR_W-1:0]       cpu_addr,
  input  logic [WORD_W-1:0]       cpu_wdata,
  output logic                    cpu_ready,
  output logic [WORD_W-1:0]       cpu_rdata,
  output logic                    mem_req,
  output logic                    mem_we,
  output logic [ADDR_W-1:0]       mem_addr,
  output logic [WORDS*WORD_W-1:0] mem_wdata,
  input  logic [WORDS*WORD_W-1:0] mem_rdata,
  input  logic                    mem_ready
);
  localparam int OFF_W  = $clog2(WORDS);
  localparam int BYTE_W = $clog2(WORD_W / 8);
  localparam int TAG_W  = ADDR_W - INDEX_W - OFF_W - BYTE_W;
  localparam int SETS   = 1 << INDEX_W;
  localparam int BLK_W  = WORDS * WORD_W;

  typedef enum logic [1:0] {S_IDLE, S_CMP, S_WB, S_FILL} state_t;

  state_t                 state;
  logic [TAG_W-1:0]       tag_arr  [SETS];
  logic [BLK_W-1:0]       data_arr [SETS];
  logic [SETS-1:0]        vld, drt;

  logic                   req_we;
  logic [TAG_W-1:0]       req_tag;
  logic [INDEX_W-1:0]     req_idx;
  logic [OFF_W-1:0]       req_off;
  logic [WORD_W-1:0]      req_wdata;
  logic                   unused_byte;
  logic                   hit;

  assign unused_byte = ^cpu_addr[BYTE_W-1:0];
  assign hit         = vld[req_idx] && (tag_arr[req_idx] == req_tag);

  assign cpu_ready = (state == S_CMP) && hit;
  assign cpu_rdata = data_arr[req_idx][req_off*WORD_W +: WORD_W];

  assign mem_req   = (state == S_WB) || (state == S_FILL);
  assign mem_we    = (state == S_WB);
  assign mem_wdata = data_arr[req_idx];
  assign mem_addr  = {(state == S_WB) ? tag_arr[req_idx] : req_tag,
                      req_idx, {(OFF_W + BYTE_W){1'b0}}};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      vld       <= '0;
      drt       <= '0;
      req_we    <= 1'b0;
      req_tag   <= '0;
      req_idx   <= '0;
      req_off   <= '0;
      req_wdata <= '0;
    end else begin
      unique case (state)
        S_IDLE: if (cpu_valid) begin
          req_we    <= cpu_we;
          req_tag   <= cpu_addr[ADDR_W-1 -: TAG_W];
          req_idx   <= cpu_addr[BYTE_W+OFF_W +: INDEX_W];
          req_off   <= cpu_addr[BYTE_W +: OFF_W];
          req_wdata <= cpu_wdata;
          state     <= S_CMP;
        end
        S_CMP: begin
          if (hit) begin
            if (req_we) drt[req_idx] <= 1'b1;
            state <= S_IDLE;
          end else if (vld[req_idx] && drt[req_idx]) begin
            state <= S_WB;
          end else begin
            state <= S_FILL;
          end
        end
        S_WB: if (mem_ready) state <= S_FILL;
        S_FILL: if (mem_ready) begin
          vld[req_idx] <= 1'b1;
          drt[req_idx] <= 1'b0;
          state        <= S_CMP;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (state == S_CMP && hit && req_we)
      data_arr[req_idx][req_off*WORD_W +: WORD_W] <= req_wdata;
    if (state == S_FILL && mem_ready) begin
      data_arr[req_idx] <= mem_rdata;
      tag_arr[req_idx]  <= req_tag;
    end
  end
endmodule

// File: rtl/wb_cache_ctrl_chk.sv
module wb_cache_ctrl_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cpu_ready,
  input logic              mem_req,
  input logic              mem_we,
  input logic              mem_ready,
  input logic [ADDR_W-1:0] mem_addr
);
  assert_idle_after_reset_R1: assert property (@(posedge clk)
    $rose(rst_n) |-> !cpu_ready && !mem_req);

  assert_hit_no_mem_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ready |-> !mem_req);

  assert_wb_then_fill_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_we && mem_ready |=> mem_req && !mem_we);

  assert_req_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ready |=> mem_req && $stable(mem_we) && $stable(mem_addr));

  assert_fill_to_compare_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_we && mem_ready |=> !mem_req);

  assert_ready_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ready |=> !cpu_ready);
endmodule

bind wb_cache_ctrl wb_cache_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_ready(cpu_ready), .mem_req(mem_req),
  .mem_we(mem_we), .mem_ready(mem_ready), .mem_addr(mem_addr)
);

// File: tb/test_wb_cache_ctrl.sv
module test_wb_cache_ctrl;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         cpu_valid = 1'b0, cpu_we = 1'b0;
  logic [31:0]  cpu_addr = '0, cpu_wdata = '0;
  logic         cpu_ready;
  logic [31:0]  cpu_rdata;
  logic         mem_req, mem_we;
  logic [31:0]  mem_addr;
  logic [127:0] mem_wdata;
  logic [127:0] mem_rdata = '0;
  logic         mem_ready = 1'b0;

  always #2.5 clk = ~clk;

  wb_cache_ctrl i_wb_cache_ctrl (
    .clk(clk), .rst_n(rst_n), .cpu_valid(cpu_valid), .cpu_we(cpu_we),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_ready(cpu_ready),
    .cpu_rdata(cpu_rdata), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .mem_ready(mem_ready)
  );

  int checks = 0, fails = 0;
  bit done = 0;

  task automatic check(bit ok, string req, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] init_word(logic [31:0] wa);
    return wa * 32'h9E3779B1 + 32'h5A5A0000;
  endfunction

  logic [127:0] mem [int unsigned];
  logic [31:0]  gold [int unsigned];

  function automatic logic [127:0] get_blk(logic [31:0] ba);
    logic [127:0] b;
    if (mem.exists(ba)) return mem[ba];
    for (int k = 0; k < 4; k++) b[32*k +: 32] = init_word(ba * 4 + k);
    return b;
  endfunction

  function automatic logic [31:0] gold_word(logic [31:0] wa);
    return gold.exists(wa) ? gold[wa] : init_word(wa);
  endfunction

  int n_rd = 0, n_wr = 0, cnt = 0, lat = 0;
  logic [31:0]  rd_addr = '0, wr_addr = '0, hold_addr = '0;
  logic [127:0] wr_data = '0;

  always @(negedge clk) begin
    if (!rst_n) begin
      mem_ready = 1'b0; cnt = 0; lat = 0;
    end else if (mem_ready) begin
      mem_ready = 1'b0; cnt = 0; lat = $urandom_range(0, 4);
    end else if (mem_req) begin
      if (cnt > 0) check(mem_addr == hold_addr, "R7 address held", mem_addr, hold_addr);
      hold_addr = mem_addr;
      if (cnt >= lat) begin
        if (mem_we) begin
          mem[mem_addr >> 4] = mem_wdata; n_wr++; wr_addr = mem_addr; wr_data = mem_wdata;
        end else begin
          mem_rdata = get_blk(mem_addr >> 4); n_rd++; rd_addr = mem_addr;
        end
        mem_ready = 1'b1;
      end else cnt++;
    end
  end

  bit          tv [1024];
  bit          td [1024];
  logic [17:0] tt [1024];

  task automatic do_op(bit we, logic [31:0] addr, logic [31:0] wd);
    logic [9:0]  idx = addr[13:4];
    bit          hit = tv[idx] && tt[idx] == addr[31:14];
    bit          exp_wb = !hit && tv[idx] && td[idx];
    logic [31:0] victim = {tt[idx], idx, 4'b0};
    int          cyc = 0;
    bit          got = 0;
    logic [31:0] rdata;
    n_rd = 0; n_wr = 0;
    cpu_addr = addr; cpu_we = we; cpu_wdata = wd; cpu_valid = 1'b1;
    while (!got && cyc < 200) begin
      @(negedge clk); cyc++;
      if (cpu_ready) got = 1;
    end
    rdata = cpu_rdata;
    cpu_valid = 1'b0;
    check(got, "R8 access completes", 128'(got), 1);
    if (hit) check(cyc == 1, "R2 hit latency", cyc, 1);
    check(n_rd == int'(!hit), "R5 fill count", n_rd, int'(!hit));
    check(n_wr == int'(exp_wb), "R6,R8 write-back count", n_wr, int'(exp_wb));
    if (!hit) check(rd_addr == {addr[31:4], 4'b0}, "R5 fill address", rd_addr, {addr[31:4], 4'b0});
    if (exp_wb && n_wr == 1) begin
      check(wr_addr == victim, "R6 victim address", wr_addr, victim);
      for (int k = 0; k < 4; k++)
        check(wr_data[32*k +: 32] == gold_word(victim / 4 + k), "R6,R9 victim word",
              wr_data[32*k +: 32], gold_word(victim / 4 + k));
    end
    if (!we) check(rdata == gold_word(addr >> 2), "R3,R4,R9 read word", rdata, gold_word(addr >> 2));
    else gold[addr >> 2] = wd;
    td[idx] = (hit ? td[idx] : 1'b0) | we;
    tv[idx] = 1'b1;
    tt[idx] = addr[31:14];
    @(negedge clk);
    check(!cpu_ready, "R10 single ready pulse", cpu_ready, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [17:0] tags [4];
    logic [9:0]  idxs [4];
    void'($urandom(32'd20240611));
    tags[0] = 18'h0; tags[1] = 18'h1; tags[2] = 18'h2A5; tags[3] = 18'h3FFFF;
    idxs[0] = 10'd0; idxs[1] = 10'd1; idxs[2] = 10'd2; idxs[3] = 10'd1023;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(!cpu_ready && !mem_req, "R1 idle after reset", {cpu_ready, mem_req}, 0);

    n_rd = 0;
    do_op(0, 32'h0000_0100, 0);
    check(n_rd == 1, "R1 first access misses", n_rd, 1);
    do_op(0, 32'h0000_0104, 0);
    do_op(1, 32'h0000_0108, 32'hCAFE_0002);
    do_op(0, 32'h0000_0108, 0);
    do_op(0, 32'h0000_010C, 0);
    do_op(0, 32'h0000_0100, 0);
    do_op(0, 32'h0000_4100, 0);
    do_op(0, 32'h0000_0100, 0);
    do_op(1, 32'hFFFF_FFFC, 32'h1234_5678);
    do_op(0, 32'h0000_3FF0, 0);
    do_op(0, 32'hFFFF_FFFC, 0);

    for (int i = 0; i < 3000; i++) begin
      logic [31:0] a;
      a = {tags[$urandom_range(0, 3)], idxs[$urandom_range(0, 3)], 2'($urandom_range(0, 3)), 2'b00};
      do_op($urandom_range(0, 1) == 1, a, $urandom);
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule